// File: doc/BRIEF.md
# SPI Master/Slave Controller

This block is a byte-wide SPI port that sits on a simple CPU register bus and runs entirely on one system clock. Software selects master or slave operation, enables the port and, in master mode, picks a serial clock rate. A single completion flag drives the interrupt line. It is raised when a byte has finished shifting, or when a master sees its select input pulled low by another master. Received bytes land in a receive buffer that is separate from the shift register, so a byte can be read while the next one shifts.

In master mode a write to the data address launches eight SCK cycles, MSB first. Data changes on the falling edge and is sampled on the rising edge. Slave selects are not generated here; software drives them through general I/O. In slave mode the external SCK and SS are passed through a synchronizer and edge-detected in the system clock domain. Each SCK high and low phase must therefore last more than two system clocks. A byte cut short by SS going high is thrown away. While enabled, the block also tells the pad logic which pins must be forced to inputs.

Register map on `bus_addr`: 0 = control (bit 0 enable, bit 1 master, bits 3:2 clock divider select), 1 = status (flag in the top data bit), 2 = data (write loads the transmit byte, read returns the receive buffer).

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control, status and receive buffer read as zero, sck_out, irq and miso_oe are low and pin_force is 0.
- R2: In master mode with the port enabled and idle, a write to address 2 starts a transfer. SCK half period is H = 2, 8, 32 or 64 system clocks for divider select 0, 1, 2 or 3. SCK rises at H clock edges after the write edge and toggles every H edges, giving exactly 8 rising edges. The written byte appears on mosi_out MSB first, and mosi_out changes only at falling edges. SCK then stays low, and the flag is set at edge 16·H after the write edge.
- R3: In master mode miso_in is sampled at each SCK rising edge, MSB first, and the completed byte is placed in the receive buffer when the flag is set.
- R4: pin_force (bit 0 MOSI, bit 1 MISO, bit 2 SCK, bit 3 SS; 1 = forced to input) is 4'b0010 in enabled master mode, 4'b1101 in enabled slave mode and 0 when disabled.
- R5: In enabled master mode with ss_is_output low, ss_in seen low after synchronization clears the master bit, sets the flag and aborts the transfer with SCK low. With ss_is_output high, a low ss_in has no effect.
- R6: In slave mode, while SS is high, miso_oe is low and SCK pulses neither shift nor set the flag. A data write in that time loads the transmit byte.
- R7: In slave mode with SS low, the loaded byte is driven on miso_out MSB first and changes after each SCK falling edge. mosi_in is sampled on rising edges, and after the eighth falling edge the flag is set and the byte is placed in the receive buffer.
- R8: When SS rises in slave mode before a byte completes, the partial bits are discarded, the receive buffer and the flag are unchanged, and the next full byte is received correctly.
- R9: The flag is cleared by a read of address 2 or by a write to address 1 with the top data bit set. A byte that completes in the same cycle as a clear leaves the flag set.
- R10: A data write while a master transfer is running is ignored and does not change the byte being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading the data address clears the flag) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Completion / mode-fault flag |
| ss_is_output | input | 1 | High when the SS pad is configured as an output by software |
| sck_in | input | 1 | SCK pad input (slave mode) |
| sck_out | output | 1 | Generated SCK (master mode) |
| mosi_in | input | 1 | MOSI pad input (slave mode) |
| mosi_out | output | 1 | MOSI drive value (master mode) |
| miso_in | input | 1 | MISO pad input (master mode) |
| miso_out | output | 1 | MISO drive value (slave mode) |
| miso_oe | output | 1 | MISO enable; low keeps MISO tri-stated |
| ss_in | input | 1 | SS pad input, active low |
| pin_force | output | 4 | Per-pin force-to-input override |

## Verification
A wrong bit counter or divider state shows at the ports within one SCK half period. SCK then toggles one edge early or late, or the flag arrives on a cycle other than 16·H after the write, and the bench compares both on every clock of a master transfer. A corrupted shift register or sample bit shows up as a wrong MSB-first sequence on mosi_out or miso_out, and as a wrong receive-buffer value at the next read. Stale slave state after SS is released shows up only at the following byte, so the bench sends a full byte straight after an aborted one. A missed mode fault is visible within three clocks of SS falling, in the control readback and in the flag.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd1;
   localparam logic [1:0] ADDR_DATA = 2'd2;

   localparam int CTRL_EN  = 0;
   localparam int CTRL_MST = 1;
   localparam int CTRL_DIV = 2;

   localparam int PIN_MOSI = 0;
   localparam int PIN_MISO = 1;
   localparam int PIN_SCK  = 2;
   localparam int PIN_SS   = 3;

   localparam int HALF_W = 7;

   // system clocks per SCK half period for each divider select
   function automatic logic [HALF_W-1:0] half_period(input logic [1:0] sel);
      logic [HALF_W-1:0] h;
      if (sel == 2'd3) h = 7'd64;
      else             h = 7'd2 << (2 * sel);
      return h;
   endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
   parameter int                WIDTH   = 2,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= RST_VAL;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= RST_VAL;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_port_sckgen.sv
module spi_port_sckgen
   import spi_port_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] div_sel,
   output logic       sck,
   output logic       rise_p,
   output logic       fall_p
);

   logic [HALF_W-1:0] ctr;
   logic [HALF_W-1:0] half;
   logic              term;

   assign half   = half_period(div_sel);
   assign term   = run && (ctr == half - 1'b1);
   assign rise_p = term && !sck;
   assign fall_p = term &&  sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr <= '0;
         sck <= 1'b0;
      end else if (!run) begin
         ctr <= '0;
         sck <= 1'b0;
      end else if (term) begin
         ctr <= '0;
         sck <= ~sck;
      end else begin
         ctr <= ctr + 1'b1;
      end
   end

   // R2: once the transfer is no longer running, SCK is parked low
   a_r2_sck_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sck);

endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              clear,
   input  logic              rise,
   input  logic              fall,
   input  logic              sdi,
   output logic              sdo,
   output logic              done,
   output logic              cnt_zero,
   output logic [DATA_W-1:0] rx_word
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic              samp;

   assign sdo      = shreg[DATA_W-1];
   assign cnt_zero = (cnt == '0);
   assign rx_word  = {shreg[DATA_W-2:0], samp};
   assign done     = fall && !clear && !load && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
         samp  <= 1'b0;
      end else if (load) begin
         shreg <= load_val;
         cnt   <= '0;
         samp  <= 1'b0;
      end else if (clear) begin
         cnt   <= '0;
         samp  <= 1'b0;
      end else begin
         if (rise) samp <= sdi;
         if (fall) begin
            shreg <= rx_word;
            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end
      end
   end

   // R7: a completed byte leaves the bit counter back at the start
   a_r7_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cnt_zero);

endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
   import spi_port_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              ss_is_output,
   input  logic              sck_in,
   output logic              sck_out,
   input  logic              mosi_in,
   output logic              mosi_out,
   input  logic              miso_in,
   output logic              miso_out,
   output logic              miso_oe,
   input  logic              ss_in,
   output logic [3:0]        pin_force
);

   localparam int FLAG_BIT = DATA_W - 1;

   generate
      if (DATA_W < 5) begin : g_bad_width
         $error("spi_port_ctrl: DATA_W must be at least 5");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_port_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              en, master, flag, busy;
   logic [1:0]        div_sel;
   logic [DATA_W-1:0] rxbuf;

   logic ss_s, sck_s, sck_prev;
   logic rise_m, fall_m, rise_s, fall_s;
   logic slave_act, fault, done, cnt_zero, sdo;
   logic wr_ctrl, wr_stat, wr_data, rd_data;
   logic load, start, abort;
   logic [DATA_W-1:0] rx_word;

   spi_port_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ss_in, sck_in}), .q({ss_s, sck_s}));

   spi_port_sckgen u_sckgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .div_sel(div_sel),
      .sck(sck_out), .rise_p(rise_m), .fall_p(fall_m));

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
   assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
   assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
   assign rd_data = bus_rd && (bus_addr == ADDR_DATA);

   assign slave_act = en && !master && !ss_s;
   assign fault     = en && master && !ss_is_output && !ss_s;
   assign rise_s    = slave_act &&  sck_s && !sck_prev;
   assign fall_s    = slave_act && !sck_s &&  sck_prev;

   assign load  = wr_data && (master ? !busy : (ss_s || cnt_zero));
   assign start = load && master && en;
   assign abort = !en || fault || (!master && ss_s);

   spi_port_shift #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load(load), .load_val(bus_wdata), .clear(abort),
      .rise(master ? rise_m : rise_s),
      .fall(master ? fall_m : fall_s),
      .sdi(master ? miso_in : mosi_in),
      .sdo(sdo), .done(done), .cnt_zero(cnt_zero), .rx_word(rx_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         master   <= 1'b0;
         div_sel  <= 2'd0;
         flag     <= 1'b0;
         busy     <= 1'b0;
         rxbuf    <= '0;
         sck_prev <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         if (wr_ctrl) begin
            en      <= bus_wdata[CTRL_EN];
            master  <= bus_wdata[CTRL_MST];
            div_sel <= bus_wdata[CTRL_DIV +: 2];
         end
         if (fault) master <= 1'b0;

         if (!en || !master || fault || done) busy <= 1'b0;
         else if (start)                        busy <= 1'b1;

         if (done) rxbuf <= rx_word;

         if (done || fault)                          flag <= 1'b1;
         else if (rd_data || (wr_stat && bus_wdata[FLAG_BIT])) flag <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_CTRL: begin
            bus_rdata[CTRL_EN]       = en;
            bus_rdata[CTRL_MST]      = master;
            bus_rdata[CTRL_DIV +: 2] = div_sel;
         end
         ADDR_STAT: bus_rdata[FLAG_BIT] = flag;
         ADDR_DATA: bus_rdata = rxbuf;
         default:   bus_rdata = '0;
      endcase
   end

   always_comb begin
      pin_force = 4'b0000;
      if (en) begin
         if (master) pin_force[PIN_MISO] = 1'b1;
         else begin
            pin_force[PIN_MOSI] = 1'b1;
            pin_force[PIN_SCK]  = 1'b1;
            pin_force[PIN_SS]   = 1'b1;
         end
      end
   end

   assign irq      = flag;
   assign mosi_out = sdo;
   assign miso_out = sdo;
   assign miso_oe  = slave_act;

   // R2: a finished byte always leaves the flag raised
   a_r2_done_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> flag);

   // R5: a mode fault demotes the port to slave and stops the transfer
   a_r5_fault_demotes: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!master && flag && !busy));

   // R3: the receive buffer only changes on a completed byte
   a_r3_rx_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(rxbuf));

   // R8: releasing SS in slave mode never touches the receive buffer
   a_r8_release_keeps_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (!master && $rose(ss_s)) |=> $stable(rxbuf));

endmodule

// File: tb/tb_spi_port_ctrl.sv
module tb_spi_port_ctrl;

   localparam time CLK_PERIOD = 10ns;
   localparam int  SL_HALF    = 6;
   localparam int  WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       irq, ss_is_output, sck_in, sck_out, mosi_in, mosi_out;
   logic       miso_in, miso_out, miso_oe, ss_in;
   logic [3:0] pin_force;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   spi_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .ss_is_output(ss_is_output), .sck_in(sck_in),
      .sck_out(sck_out), .mosi_in(mosi_in), .mosi_out(mosi_out),
      .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
      .ss_in(ss_in), .pin_force(pin_force));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         checks++; fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp_v, cycles);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // Reference model of a master transfer: the expected SCK level and flag
   // are derived from the edge count k since the write edge.
   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rxpat, input int h,
                              input bit inject_wr, input bit clr_at_done,
                              output logic [7:0] seen_mosi);
      int  falls = 0;
      bit  prev  = 1'b0;
      bit  exp_sck, exp_irq;
      seen_mosi = 8'h00;
      miso_in = rxpat[7];
      bus_write(2'd2, tx);
      for (int k = 0; k <= 16*h + 2; k++) begin
         exp_sck = (k < 16*h) && (((k / h) % 2) == 1);
         exp_irq = (k >= 16*h);
         chk(sck_out == exp_sck, "R2 sck waveform", sck_out, exp_sck);
         chk(irq == exp_irq, "R2 flag timing", irq, exp_irq);
         if (sck_out && !prev) seen_mosi = {seen_mosi[6:0], mosi_out};
         if (!sck_out && prev) begin
            falls++;
            if (falls < 8) miso_in = rxpat[7-falls];
         end
         prev = sck_out;
         if (inject_wr && k == 3) begin
            bus_addr = 2'd2; bus_wdata = 8'hFF; bus_wr = 1'b1;
         end
         if (inject_wr && k == 4) bus_wr = 1'b0;
         if (clr_at_done && k == 16*h - 1) begin
            bus_addr = 2'd1; bus_wdata = 8'h80; bus_wr = 1'b1;
         end
         if (clr_at_done && k == 16*h) bus_wr = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic slave_bits(input logic [7:0] pat, input int nbits, output logic [7:0] got);
      got = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         mosi_in = pat[7-i];
         repeat (SL_HALF) @(negedge clk);
         got = {got[6:0], miso_out};
         sck_in = 1'b1;
         repeat (SL_HALF) @(negedge clk);
         sck_in = 1'b0;
      end
      repeat (SL_HALF) @(negedge clk);
   endtask

   initial begin
      logic [7:0] rd, seen;
      ss_is_output = 1'b0; ss_in = 1'b1; sck_in = 1'b0; mosi_in = 1'b0; miso_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(2'd0, rd); chk(rd == 8'h00, "R1 control reset", rd, 0);
      bus_read(2'd1, rd); chk(rd == 8'h00, "R1 status reset", rd, 0);
      bus_read(2'd2, rd); chk(rd == 8'h00, "R1 rx buffer reset", rd, 0);
      chk(sck_out == 1'b0 && irq == 1'b0 && miso_oe == 1'b0, "R1 outputs low",
          {sck_out, irq, miso_oe}, 0);
      chk(pin_force == 4'b0000, "R1 no override when disabled", pin_force, 0);

      // master, divide by 4
      bus_write(2'd0, 8'b0000_0011);
      chk(pin_force == 4'b0010, "R4 master override", pin_force, 4'b0010);
      master_xfer(8'hA5, 8'h3C, 2, 1'b0, 1'b0, seen);
      chk(seen == 8'hA5, "R2 mosi MSB first", seen, 8'hA5);
      bus_read(2'd2, rd); chk(rd == 8'h3C, "R3 master rx byte", rd, 8'h3C);
      chk(irq == 1'b0, "R9 read of data clears flag", irq, 0);

      // divide by 16, write during transfer ignored, clear by status write
      bus_write(2'd0, 8'b0000_0111);
      master_xfer(8'h96, 8'h5A, 8, 1'b1, 1'b0, seen);
      chk(seen == 8'h96, "R10 busy write ignored", seen, 8'h96);
      bus_read(2'd2, rd); chk(rd == 8'h5A, "R3 master rx byte div16", rd, 8'h5A);
      master_xfer(8'h0F, 8'hC1, 8, 1'b0, 1'b0, seen);
      bus_write(2'd1, 8'h80);
      chk(irq == 1'b0, "R9 status write clears flag", irq, 0);

      // clear colliding with completion: flag stays set
      bus_write(2'd0, 8'b0000_0011);
      master_xfer(8'h81, 8'h18, 2, 1'b0, 1'b1, seen);
      chk(irq == 1'b1, "R9 completion wins over clear", irq, 1);
      bus_read(2'd2, rd); chk(rd == 8'h18, "R3 rx byte after collision", rd, 8'h18);

      // slave mode
      bus_write(2'd0, 8'b0000_0001);
      chk(pin_force == 4'b1101, "R4 slave override", pin_force, 4'b1101);
      bus_write(2'd2, 8'hC3);
      slave_bits(8'hFF, 3, seen);
      chk(miso_oe == 1'b0, "R6 miso tri-stated while SS high", miso_oe, 0);
      chk(irq == 1'b0, "R6 SCK ignored while SS high", irq, 0);
      ss_in = 1'b0;
      repeat (4) @(negedge clk);
      chk(miso_oe == 1'b1, "R6 miso enabled after SS low", miso_oe, 1);
      slave_bits(8'h6B, 8, seen);
      chk(seen == 8'hC3, "R7 slave miso MSB first", seen, 8'hC3);
      chk(irq == 1'b1, "R7 slave flag after byte", irq, 1);
      bus_read(2'd2, rd); chk(rd == 8'h6B, "R7 slave rx byte", rd, 8'h6B);

      // partial byte then a full one
      ss_in = 1'b1; repeat (4) @(negedge clk);
      bus_write(2'd2, 8'h11);
      ss_in = 1'b0; repeat (4) @(negedge clk);
      slave_bits(8'hF0, 5, seen);
      ss_in = 1'b1; repeat (6) @(negedge clk);
      chk(irq == 1'b0, "R8 partial byte sets no flag", irq, 0);
      bus_read(2'd2, rd); chk(rd == 8'h6B, "R8 partial byte dropped", rd, 8'h6B);
      bus_write(2'd2, 8'h11);
      ss_in = 1'b0; repeat (4) @(negedge clk);
      slave_bits(8'h2D, 8, seen);
      chk(seen == 8'h11, "R8 next byte transmits cleanly", seen, 8'h11);
      bus_read(2'd2, rd); chk(rd == 8'h2D, "R8 next byte received", rd, 8'h2D);
      ss_in = 1'b1; repeat (4) @(negedge clk);

      // mode fault while a slow transfer runs
      bus_write(2'd0, 8'b0000_1111);
      bus_write(2'd2, 8'h55);
      repeat (20) @(negedge clk);
      ss_in = 1'b0;
      repeat (4) @(negedge clk);
      bus_read(2'd0, rd); chk(rd[1] == 1'b0, "R5 fault clears master bit", rd, rd & 8'hFD);
      chk(irq == 1'b1, "R5 fault raises flag", irq, 1);
      chk(sck_out == 1'b0, "R5 fault stops sck", sck_out, 0);
      chk(pin_force == 4'b1101, "R4 override follows fault", pin_force, 4'b1101);
      ss_in = 1'b1; repeat (4) @(negedge clk);
      bus_write(2'd1, 8'h80);

      // SS configured as output: low input ignored
      ss_is_output = 1'b1;
      bus_write(2'd0, 8'b0000_0011);
      ss_in = 1'b0; repeat (5) @(negedge clk);
      bus_read(2'd0, rd); chk(rd[1] == 1'b1, "R5 no fault with SS as output", rd[1], 1);
      chk(irq == 1'b0, "R5 no flag with SS as output", irq, 0);

      finish_run();
   end

endmodule